// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block keeps one 64-bit up-counter that advances once per clock while the timer is enabled, and a set of comparator channels that watch it. When a channel's comparator equals the counter, the channel sets a sticky status bit. An enabled channel then holds its interrupt output high until software clears that bit. A channel can be one-shot or periodic. In periodic mode it adds a stored period to its comparator after each match, so it fires again a fixed number of ticks later.

Software reaches everything through a small 32-bit register bus. Writes take effect at the clock edge that samples them. A read strobe returns data one cycle later, together with a valid flag. Software stops the counter, presets it in two halves, programs the channels, and then starts it. A legacy routing mode sends channel 0 and channel 1 to two dedicated interrupt outputs. Every other channel, and channels 0 and 1 when legacy routing is off, drives one of a set of shared interrupt lines chosen by its route field.

Top module: `evt_timer`

## Requirements
- R1: After reset the global config reads 0, the status register reads 0, both counter halves read 0, every channel config reads 0, every comparator half reads 0xFFFFFFFF, and all interrupt outputs are low.
- R2: The capability register at 0x000 reads {vendor[31:16], legacy-capable bit 15 = 1, bits 14:13 = 0, channel count minus one in bits 12:8, revision 0x01 in bits 7:0}. The period register at 0x004 reads the tick length in femtoseconds, a value between 100000 and 100000000.
- R3: The global config register is at 0x010, with bit 0 = run and bit 1 = legacy routing. While run is 0 the counter holds its value. The counter halves at 0x0F0 (low) and 0x0F4 (high) accept writes only while run is 0. A write while running is ignored.
- R4: While run is 1 the counter increases by exactly one on every clock.
- R5: Channel n has registers at 0x100 + 0x20·n, with config at +0x0, comparator low at +0x8 and comparator high at +0x0C. A match is exact equality between the counter and the comparator. The channel's status bit is set at the clock edge after the one on which the counter reached the comparator value. A one-shot channel fires once per counter pass.
- R6: The channel config bits are: bit 0 = interrupt enable, bit 1 = periodic, bit 2 = set-value, bit 3 = 32-bit mode, and bits 6:4 = route. If periodic and set-value are both 1, the first comparator write loads the comparator and the second loads the period. The second write also clears set-value. After each match, a periodic channel adds the period to its comparator.
- R7: The status register at 0x020 holds one sticky bit per channel, at bit n, and writing 1 to a bit clears it. A channel's interrupt is asserted while its status bit and its interrupt enable are both 1.
- R8: With legacy routing on, channel 0 drives only `irq_tick` and channel 1 drives only `irq_rtc`. With legacy routing off, both legacy outputs stay low and channels 0 and 1 use their route fields.
- R9: Channels 2 and up always drive `irq_line[route]`. Channels that share a route are ORed onto that line.
- R10: In 32-bit mode a channel compares, and reloads, only the low 32 bits of the counter and comparator. In 64-bit mode all 64 bits must be equal.
- R11: A comparator value below the current count does not fire until the counter wraps around to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| bus_rvalid | output | 1 | Read data valid |
| irq_tick | output | 1 | Legacy system-tick interrupt (channel 0) |
| irq_rtc | output | 1 | Legacy real-time-clock interrupt (channel 1) |
| irq_line | output | NUM_IRQ | Routed interrupt lines |

## Verification
The assertions check on every cycle that the counter holds while stopped and steps by one while running. They also check that a status bit rises only after a comparator hit, that a clear write lowers it, that the second handshake write drops set-value, and that the legacy outputs stay quiet with legacy routing off. Only the bench scenarios can show the exact cycle on which an interrupt appears. The same holds for the periodic reload arithmetic, the routing of each channel to its line, and the contrast between 32-bit and 64-bit comparison across a low-word wrap.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam logic [11:0] OFS_CAP    = 12'h000;
    localparam logic [11:0] OFS_PERIOD = 12'h004;
    localparam logic [11:0] OFS_GCFG   = 12'h010;
    localparam logic [11:0] OFS_STAT   = 12'h020;
    localparam logic [11:0] OFS_CNT_LO = 12'h0F0;
    localparam logic [11:0] OFS_CNT_HI = 12'h0F4;
    localparam logic [3:0]  CH_REGION  = 4'h1;
    localparam logic [2:0]  CH_CFG     = 3'd0;
    localparam logic [2:0]  CH_CMP_LO  = 3'd2;
    localparam logic [2:0]  CH_CMP_HI  = 3'd3;

    localparam int CFG_IRQEN    = 0;
    localparam int CFG_PERIODIC = 1;
    localparam int CFG_SETVAL   = 2;
    localparam int CFG_MODE32   = 3;
    localparam int CFG_ROUTE    = 4;

    localparam int GCFG_RUN    = 0;
    localparam int GCFG_LEGACY = 1;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt
);
    localparam int HI_W = CNT_W - 32;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (run) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end else begin
            if (wr_lo) s_d.cnt[31:0] = wdata;
            if (wr_hi) s_d.cnt[CNT_W-1:32] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int ROUTE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [63:0]        cnt,
    input  logic               cnt_run,
    input  logic               cfg_wr,
    input  logic               cmp_lo_wr,
    input  logic               cmp_hi_wr,
    input  logic [31:0]        wdata,
    input  logic               stat_clr,
    output logic               hit,
    output logic               status,
    output logic               level,
    output logic [ROUTE_W-1:0] route,
    output logic [31:0]        cfg_rd,
    output logic [63:0]        cmp_val
);
    typedef struct packed {
        logic               irq_en;
        logic               periodic;
        logic               setval;
        logic               mode32;
        logic [ROUTE_W-1:0] route;
        logic               phase;
        logic               status;
        logic [63:0]        cmp;
        logic [63:0]        period;
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      handshake;
    logic      any_cmp_wr;

    assign any_cmp_wr = cmp_lo_wr || cmp_hi_wr;
    assign handshake  = s_q.periodic && s_q.setval;

    always_comb begin
        if (s_q.mode32) hit = cnt_run && (cnt[31:0] == s_q.cmp[31:0]);
        else            hit = cnt_run && (cnt == s_q.cmp);
    end

    always_comb begin
        s_d = s_q;
        if (hit) begin
            s_d.status = 1'b1;
            if (s_q.periodic) begin
                if (s_q.mode32) s_d.cmp[31:0] = s_q.cmp[31:0] + s_q.period[31:0];
                else            s_d.cmp       = s_q.cmp + s_q.period;
            end
        end else if (stat_clr) begin
            s_d.status = 1'b0;
        end

        if (cfg_wr) begin
            s_d.irq_en   = wdata[CFG_IRQEN];
            s_d.periodic = wdata[CFG_PERIODIC];
            s_d.setval   = wdata[CFG_SETVAL];
            s_d.mode32   = wdata[CFG_MODE32];
            s_d.route    = wdata[CFG_ROUTE +: ROUTE_W];
            s_d.phase    = 1'b0;
        end

        if (any_cmp_wr) begin
            if (handshake && s_q.phase) begin
                if (cmp_lo_wr) s_d.period[31:0]  = wdata;
                else           s_d.period[63:32] = wdata;
                s_d.phase  = 1'b0;
                s_d.setval = 1'b0;
            end else begin
                if (cmp_lo_wr) s_d.cmp[31:0]  = wdata;
                else           s_d.cmp[63:32] = wdata;
                if (handshake) s_d.phase = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cmp    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign status  = s_q.status;
    assign level   = s_q.status && s_q.irq_en;
    assign route   = s_q.route;
    assign cmp_val = s_q.cmp;

    always_comb begin
        cfg_rd = '0;
        cfg_rd[CFG_IRQEN]            = s_q.irq_en;
        cfg_rd[CFG_PERIODIC]         = s_q.periodic;
        cfg_rd[CFG_SETVAL]           = s_q.setval;
        cfg_rd[CFG_MODE32]           = s_q.mode32;
        cfg_rd[CFG_ROUTE +: ROUTE_W] = s_q.route;
    end

    assert_status_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(hit));

    assert_setval_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cmp_wr && handshake && s_q.phase && !cfg_wr) |=> !s_q.setval);

    assert_status_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !hit) |=> !status);
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
    parameter int NUM_CH  = 4,
    parameter int NUM_IRQ = 8,
    parameter int ROUTE_W = 3
) (
    input  logic [NUM_CH-1:0]         level,
    input  logic [NUM_CH*ROUTE_W-1:0] routes,
    input  logic                      legacy,
    output logic                      irq_tick,
    output logic                      irq_rtc,
    output logic [NUM_IRQ-1:0]        irq_line
);
    always_comb begin
        irq_tick = 1'b0;
        irq_rtc  = 1'b0;
        irq_line = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (legacy && i == 0)      irq_tick = irq_tick | level[i];
            else if (legacy && i == 1) irq_rtc  = irq_rtc | level[i];
            else if (level[i])
                irq_line[routes[i*ROUTE_W +: ROUTE_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter int          NUM_IRQ   = 8,
    parameter logic [15:0] VENDOR_ID = 16'hA5C3,
    parameter int          TICK_FS   = 10000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               irq_tick,
    output logic               irq_rtc,
    output logic [NUM_IRQ-1:0] irq_line
);
    localparam int ROUTE_W = $clog2(NUM_IRQ);
    localparam logic [31:0] CAP_WORD =
        {VENDOR_ID, 1'b1, 2'b00, 5'(NUM_CH - 1), 8'h01};

    typedef struct packed {
        logic        run;
        logic        legacy;
        logic [31:0] rdata;
        logic        rvalid;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [63:0]              cnt;
    logic                     aligned, in_ch;
    logic                     cnt_wr_lo, cnt_wr_hi;
    logic [NUM_CH-1:0]        hit, status, level;
    logic [NUM_CH-1:0]        cfg_wr, cmp_lo_wr, cmp_hi_wr, stat_clr;
    logic [NUM_CH*ROUTE_W-1:0] routes;
    logic [31:0]              cfg_rd [NUM_CH];
    logic [63:0]              cmp_val [NUM_CH];
    logic [31:0]              rd_word;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign in_ch     = aligned && (bus_addr[11:8] == CH_REGION);
    assign cnt_wr_lo = bus_wr && (bus_addr == OFS_CNT_LO);
    assign cnt_wr_hi = bus_wr && (bus_addr == OFS_CNT_HI);

    evt_counter #(.CNT_W(64)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.run),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel          = bus_wr && in_ch && (bus_addr[7:5] == 3'(g));
        assign cfg_wr[g]    = sel && (bus_addr[4:2] == CH_CFG);
        assign cmp_lo_wr[g] = sel && (bus_addr[4:2] == CH_CMP_LO);
        assign cmp_hi_wr[g] = sel && (bus_addr[4:2] == CH_CMP_HI);
        assign stat_clr[g]  = bus_wr && (bus_addr == OFS_STAT) && bus_wdata[g];

        evt_channel #(.ROUTE_W(ROUTE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .cnt_run   (s_q.run),
            .cfg_wr    (cfg_wr[g]),
            .cmp_lo_wr (cmp_lo_wr[g]),
            .cmp_hi_wr (cmp_hi_wr[g]),
            .wdata     (bus_wdata),
            .stat_clr  (stat_clr[g]),
            .hit       (hit[g]),
            .status    (status[g]),
            .level     (level[g]),
            .route     (routes[g*ROUTE_W +: ROUTE_W]),
            .cfg_rd    (cfg_rd[g]),
            .cmp_val   (cmp_val[g])
        );
    end

    evt_irq_route #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ), .ROUTE_W(ROUTE_W)) u_route (
        .level    (level),
        .routes   (routes),
        .legacy   (s_q.legacy),
        .irq_tick (irq_tick),
        .irq_rtc  (irq_rtc),
        .irq_line (irq_line)
    );

    always_comb begin
        rd_word = '0;
        if (bus_addr == OFS_CAP)         rd_word = CAP_WORD;
        else if (bus_addr == OFS_PERIOD) rd_word = 32'(TICK_FS);
        else if (bus_addr == OFS_GCFG) begin
            rd_word[GCFG_RUN]    = s_q.run;
            rd_word[GCFG_LEGACY] = s_q.legacy;
        end
        else if (bus_addr == OFS_STAT)   rd_word = 32'(status);
        else if (bus_addr == OFS_CNT_LO) rd_word = cnt[31:0];
        else if (bus_addr == OFS_CNT_HI) rd_word = cnt[63:32];
        else if (in_ch) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr[7:5] == 3'(i)) begin
                    case (bus_addr[4:2])
                        CH_CFG:    rd_word = cfg_rd[i];
                        CH_CMP_LO: rd_word = cmp_val[i][31:0];
                        CH_CMP_HI: rd_word = cmp_val[i][63:32];
                        default:   rd_word = '0;
                    endcase
                end
            end
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = bus_rd;
        if (bus_rd) s_d.rdata = rd_word;
        if (bus_wr && bus_addr == OFS_GCFG) begin
            s_d.run    = bus_wdata[GCFG_RUN];
            s_d.legacy = bus_wdata[GCFG_LEGACY];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_rvalid = s_q.rvalid;

    assert_legacy_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.legacy |-> (!irq_tick && !irq_rtc));
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
    localparam int NUM_IRQ = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [11:0]        bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic               bus_rvalid;
    logic               irq_tick, irq_rtc;
    logic [NUM_IRQ-1:0] irq_line;

    int n_chk = 0;
    int n_fail = 0;
    int edges = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    evt_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_tick(irq_tick), .irq_rtc(irq_rtc),
        .irq_line(irq_line)
    );

    // monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        exp_t e;
        if (bus_rvalid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL [scoreboard] unexpected read data act=%h exp=none", bus_rdata);
            end else begin
                e = sb.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL [%s] act=%h exp=%h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        sb.push_back('{exp, tag});
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_to(input int t);
        while (edges < t) @(negedge clk);
    endtask

    function automatic logic [11:0] cha(input int ch, input int off);
        return 12'(32'h100 + ch * 32 + off);
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL [watchdog] run hung act=running exp=done");
        report();
    end

    initial begin
        int e_run, s_stop;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h010, 32'h0, "R1 gcfg");
        rd(12'h020, 32'h0, "R1 status");
        rd(12'h0F0, 32'h0, "R1 cnt lo");
        rd(12'h0F4, 32'h0, "R1 cnt hi");
        rd(cha(0, 0), 32'h0, "R1 ch0 cfg");
        rd(cha(3, 8), 32'hFFFF_FFFF, "R1 ch3 cmp lo");
        rd(cha(3, 12), 32'hFFFF_FFFF, "R1 ch3 cmp hi");
        chk({irq_tick, irq_rtc, irq_line}, 64'h0, "R1 irq outputs");
        // R2 capability and period
        rd(12'h000, 32'hA5C3_8301, "R2 capability");
        rd(12'h004, 32'd10000000, "R2 period");

        // R3/R4 counter run, ignored write, hold
        wr(12'h0F0, 32'd1000);
        wr(12'h0F4, 32'd0);
        wr(12'h010, 32'h1);
        e_run = edges;
        wr(12'h0F0, 32'd7);
        repeat (5) @(negedge clk);
        wr(12'h010, 32'h0);
        s_stop = edges;
        rd(12'h0F0, 32'(1000 + s_stop - e_run), "R4 count after run / R3 write ignored");
        repeat (6) @(negedge clk);
        rd(12'h0F0, 32'(1000 + s_stop - e_run), "R3 hold while stopped");
        rd(12'h0F4, 32'h0, "R3 high word");

        // R5/R7/R9 one-shot, legacy on
        wr(12'h0F0, 32'd0);
        wr(cha(0, 0), 32'h01);
        wr(cha(0, 8), 32'd20);
        wr(cha(0, 12), 32'd0);
        wr(cha(2, 0), 32'h50);
        wr(cha(2, 8), 32'd10);
        wr(cha(2, 12), 32'd0);
        wr(12'h010, 32'h3);
        e_run = edges;
        wait_to(e_run + 20);
        chk(64'(irq_tick), 64'h0, "R5 no fire before match edge");
        wait_to(e_run + 21);
        chk(64'(irq_tick), 64'h1, "R5 fire one edge after match / R8 tick");
        chk(64'(irq_rtc), 64'h0, "R8 rtc quiet");
        chk(64'(irq_line), 64'h0, "R7 masked ch2 keeps line low");
        wait_to(e_run + 40);
        rd(12'h020, 32'h5, "R7 sticky status ch0 ch2");
        wr(cha(2, 0), 32'h51);
        chk(64'(irq_line), 64'h20, "R9 ch2 on route 5 once enabled");
        wr(12'h020, 32'h4);
        chk(64'(irq_line), 64'h0, "R7 clear ch2 drops line");
        rd(12'h020, 32'h1, "R7 only ch2 cleared");
        wr(12'h020, 32'h1);
        chk(64'(irq_tick), 64'h0, "R7 clear ch0 drops tick");
        repeat (100) @(negedge clk);
        chk(64'(irq_tick), 64'h0, "R5 one-shot does not refire");

        // R8 legacy off: ch0 uses its route
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'd0);
        wr(cha(0, 0), 32'h31);
        wr(cha(0, 8), 32'd8);
        wr(12'h010, 32'h1);
        e_run = edges;
        wait_to(e_run + 8);
        chk(64'(irq_line), 64'h0, "R8 route 3 before match");
        wait_to(e_run + 9);
        chk(64'(irq_line), 64'h08, "R8 ch0 on route 3");
        chk(64'(irq_tick), 64'h0, "R8 tick quiet when legacy off");
        wait_to(e_run + 12);
        chk(64'(irq_line), 64'h28, "R9 ch2 on route 5 alongside ch0");
        wr(12'h020, 32'h5);

        // R6 periodic with set-value handshake, 32-bit
        wr(12'h010, 32'h0);
        wr(12'h0F0, 32'd0);
        wr(cha(1, 0), 32'h0F);
        wr(cha(1, 8), 32'd30);
        wr(cha(1, 8), 32'd50);
        rd(cha(1, 0), 32'h0B, "R6 set-value self-clears");
        rd(cha(1, 8), 32'd30, "R6 first write is comparator");
        wr(12'h010, 32'h3);
        e_run = edges;
        wait_to(e_run + 30);
        chk(64'(irq_rtc), 64'h0, "R6 no fire before first match");
        wait_to(e_run + 31);
        chk(64'(irq_rtc), 64'h1, "R6 first fire / R8 rtc");
        wr(12'h020, 32'h2);
        chk(64'(irq_rtc), 64'h0, "R7 rtc cleared");
        wait_to(e_run + 80);
        chk(64'(irq_rtc), 64'h0, "R6 no early refire");
        wait_to(e_run + 81);
        chk(64'(irq_rtc), 64'h1, "R6 refire after period 50");
        rd(cha(1, 8), 32'd130, "R6 comparator advanced by period");

        // R10/R11 wrap in 32-bit mode, 64-bit channel stays silent
        wr(12'h010, 32'h0);
        wr(cha(1, 0), 32'h0);
        wr(cha(3, 0), 32'h69);
        wr(cha(3, 8), 32'd5);
        wr(cha(3, 12), 32'd0);
        wr(12'h0F0, 32'hFFFF_FFF0);
        wr(12'h0F4, 32'd0);
        wr(12'h020, 32'hF);
        chk(64'(irq_line), 64'h0, "R7 all status cleared");
        wr(12'h010, 32'h1);
        e_run = edges;
        wait_to(e_run + 21);
        chk(64'(irq_line), 64'h0, "R11 past comparator waits for wrap");
        wait_to(e_run + 22);
        chk(64'(irq_line), 64'h40, "R11 fires after wrap / R10 low-word compare");
        wait_to(e_run + 30);
        chk(64'(irq_line), 64'h40, "R10 64-bit ch0 ignores low-word match");
        wr(12'h010, 32'h0);
        rd(12'h0F4, 32'h1, "R4 carry into high word");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL [scoreboard] pending reads act=%0d exp=0", sb.size());
        end
        report();
    end
endmodule